// File: doc/BRIEF.md
# Banked Interrupt Flag Controller

This block collects sixteen event inputs into four banks of four sources. A rising edge on an event input latches a flag bit. Software reads and clears the flags and turns each source on or off through a byte-wide register port. Each bank drives one level-sensitive interrupt line. The line is high while any flag of that bank is both latched and enabled.

The banks sit at a fixed stride of 0x10, at 0x30, 0x40, 0x50 and 0x60. Within a bank, the flag register is at offset 0x0 and the enable register is at offset 0x4. Flags are cleared by writing ones. The enable register is written in set/clear style: bit 7 selects whether the ones in the low nibble turn sources on or off.

Software initialises the block by writing 0x0F to every enable register and then to every flag register. This turns off and clears all sources. To service a bank, software reads its flags, ANDs them with its enables, and clears each pending source one at a time, starting from bit 0.

Top module: `irq_bank_ctrl`

## Requirements
- R1: After reset, all flags and enables read 0 and all four interrupt outputs are low.
- R2: A 0-to-1 transition of `evt_i[4*b+s]`, seen between two rising clock edges, sets flag bit s of bank b at that edge. An input that stays high sets the flag only once.
- R3: A write to a flag register (address `0x30+0x10*b`) clears every flag bit whose written bit in [3:0] is 1. Bits written 0 are unchanged, and data bits [7:4] are ignored.
- R4: If a clear-write to a flag and a rising edge of that flag's event arrive in the same cycle, the flag ends up set.
- R5: A write to an enable register (address `0x34+0x10*b`) with data bit 7 = 1 sets every enable bit whose written bit in [3:0] is 1. The other enable bits are unchanged.
- R6: A write to an enable register with data bit 7 = 0 clears every enable bit whose written bit in [3:0] is 1. The other enable bits are unchanged.
- R7: `irq_lvl_o[b]` is registered and equals the OR over s of (flag AND enable) of bank b as it stood one cycle earlier. Bit 0 is the level-3 line (bank 0x30) and bit 3 is the level-6 line (bank 0x60).
- R8: Reads are combinational on `bus_addr`. A flag register returns the flags in [3:0], and an enable register returns the enables in [3:0]. Bits [7:4] read 0.
- R9: Any address other than the eight bank registers reads 0, and writes to it change no flag and no enable.
- R10: Writing 0x0F to every enable register and then to every flag register leaves all enables and flags at 0 and all interrupt outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| evt_i | input | 16 | Event inputs; bit 4*b+s is source s of bank b |
| irq_lvl_o | output | 4 | Interrupt levels 3 to 6, one per bank |

## Verification
A wrong flag or enable bit shows up at the ports in one of two ways. It appears on `bus_rdata` as soon as that register is addressed. It also appears on the bank's interrupt line one clock later, whenever the partner bit lets it through. The bench runs a cycle-accurate reference model of all flags, enables and levels, and compares the interrupt lines on every cycle. A stuck edge detector or a misrouted strobe therefore diverges on the next event or access that touches it. Periodic sweeps read back all eight registers and the unmapped addresses. This catches corruption that stays hidden while the partner bit is 0.

// File: rtl/irqbk_pkg.sv
package irqbk_pkg;
    parameter int NUM_BANKS = 4;
    parameter int SRC_W     = 4;
    parameter int DATA_W    = 8;
    parameter int ADDR_W    = 8;
    parameter int BANK_BASE = 3;   // upper address nibble of bank 0
    parameter int FLAG_OFS  = 0;
    parameter int EN_OFS    = 4;
    localparam int NUM_SRC  = NUM_BANKS * SRC_W;
    localparam int SETCLR_BIT = DATA_W - 1;

    typedef struct packed {
        logic [SRC_W-1:0] prev;
        logic [SRC_W-1:0] flag;
        logic [SRC_W-1:0] en;
        logic             irq;
    } bank_state_t;
endpackage

// File: rtl/irqbk_decode.sv
module irqbk_decode
    import irqbk_pkg::*;
(
    input  logic [ADDR_W-1:0]    addr_i,
    output logic [NUM_BANKS-1:0] bank_hit_o,
    output logic                 is_flag_o,
    output logic                 is_en_o
);
    localparam int LO_W = 4;

    logic [ADDR_W-LO_W-1:0] hi_w;
    logic [LO_W-1:0]        lo_w;

    assign hi_w = addr_i[ADDR_W-1:LO_W];
    assign lo_w = addr_i[LO_W-1:0];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hit
        assign bank_hit_o[b] = (hi_w == (ADDR_W-LO_W)'(BANK_BASE + b));
    end

    assign is_flag_o = (lo_w == LO_W'(FLAG_OFS));
    assign is_en_o   = (lo_w == LO_W'(EN_OFS));
endmodule

// File: rtl/irqbk_bank.sv
module irqbk_bank
    import irqbk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_W-1:0]  evt_i,
    input  logic              flag_wr_i,
    input  logic              en_wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [SRC_W-1:0]  flag_o,
    output logic [SRC_W-1:0]  en_o,
    output logic              irq_o
);
    bank_state_t st_d, st_q;

    always_comb begin
        logic [SRC_W-1:0] rise_w;
        logic [SRC_W-1:0] clr_w;
        st_d      = st_q;
        rise_w    = evt_i & ~st_q.prev;
        clr_w     = flag_wr_i ? wdata_i[SRC_W-1:0] : '0;
        st_d.prev = evt_i;
        st_d.flag = (st_q.flag & ~clr_w) | rise_w;   // set wins over clear
        if (en_wr_i) begin
            if (wdata_i[SETCLR_BIT])
                st_d.en = st_q.en | wdata_i[SRC_W-1:0];
            else
                st_d.en = st_q.en & ~wdata_i[SRC_W-1:0];
        end
        st_d.irq = |(st_q.flag & st_q.en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
    assign en_o   = st_q.en;
    assign irq_o  = st_q.irq;
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
    import irqbk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_SRC-1:0]   evt_i,
    output logic [NUM_BANKS-1:0] irq_lvl_o
);
    logic [NUM_BANKS-1:0] bank_hit_w;
    logic                 is_flag_w;
    logic                 is_en_w;
    logic [NUM_SRC-1:0]   flag_vec;
    logic [NUM_SRC-1:0]   en_vec;
    logic                 wr_w;

    assign wr_w = bus_sel & bus_we;

    irqbk_decode u_dec (
        .addr_i     (bus_addr),
        .bank_hit_o (bank_hit_w),
        .is_flag_o  (is_flag_w),
        .is_en_o    (is_en_w)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        irqbk_bank u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt_i     (evt_i[b*SRC_W +: SRC_W]),
            .flag_wr_i (wr_w & bank_hit_w[b] & is_flag_w),
            .en_wr_i   (wr_w & bank_hit_w[b] & is_en_w),
            .wdata_i   (bus_wdata),
            .flag_o    (flag_vec[b*SRC_W +: SRC_W]),
            .en_o      (en_vec[b*SRC_W +: SRC_W]),
            .irq_o     (irq_lvl_o[b])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_hit_w[b] && is_flag_w)
                bus_rdata[SRC_W-1:0] = flag_vec[b*SRC_W +: SRC_W];
            if (bank_hit_w[b] && is_en_w)
                bus_rdata[SRC_W-1:0] = en_vec[b*SRC_W +: SRC_W];
        end
    end
endmodule

// File: rtl/irqbk_checker.sv
module irqbk_checker
    import irqbk_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_sel,
    input logic                 bus_we,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [DATA_W-1:0]    bus_wdata,
    input logic [DATA_W-1:0]    bus_rdata,
    input logic [NUM_SRC-1:0]   evt_i,
    input logic [NUM_SRC-1:0]   flag_vec,
    input logic [NUM_SRC-1:0]   en_vec,
    input logic [NUM_BANKS-1:0] irq_lvl_o
);
    AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:SRC_W] == '0);  // R8

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_lvl
        AST_LVL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
            irq_lvl_o[b] == $past(|(flag_vec[b*SRC_W +: SRC_W] & en_vec[b*SRC_W +: SRC_W])));  // R7
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        localparam logic [ADDR_W-1:0] FA = ADDR_W'((BANK_BASE + i / SRC_W) * 16 + FLAG_OFS);
        localparam logic [ADDR_W-1:0] EA = ADDR_W'((BANK_BASE + i / SRC_W) * 16 + EN_OFS);
        localparam int S = i % SRC_W;

        AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(evt_i[i]) |=> flag_vec[i]);  // R2
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_sel && bus_we && bus_addr == FA && bus_wdata[S] && $rose(evt_i[i])) |=> flag_vec[i]);  // R4
        AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_sel && bus_we && bus_addr == FA && bus_wdata[S] && !evt_i[i]) |=> !flag_vec[i]);  // R3
        AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_sel && bus_we && bus_addr == EA && bus_wdata[SETCLR_BIT] && bus_wdata[S]) |=> en_vec[i]);  // R5
        AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_sel && bus_we && bus_addr == EA && !bus_wdata[SETCLR_BIT] && bus_wdata[S]) |=> !en_vec[i]);  // R6
        AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(bus_sel && bus_we && bus_addr == EA && bus_wdata[S]) |=> $stable(en_vec[i]));  // R9
    end
endmodule

bind irq_bank_ctrl irqbk_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .evt_i     (evt_i),
    .flag_vec  (flag_vec),
    .en_vec    (en_vec),
    .irq_lvl_o (irq_lvl_o)
);

// File: tb/irq_bank_ctrl_bench.sv
module irq_bank_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 4;
    localparam int NS = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic [15:0] evt_i = '0;
    logic [3:0]  irq_lvl_o;

    int n_chk = 0;
    int n_fail = 0;

    logic [15:0] m_flag = '0;
    logic [15:0] m_en = '0;
    logic [15:0] m_prev = '0;
    logic [3:0]  m_lvl = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_bank_ctrl u_irq_bank_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_i(evt_i), .irq_lvl_o(irq_lvl_o)
    );

    function automatic logic [7:0] fa(input int b);
        return 8'((3 + b) * 16);
    endfunction
    function automatic logic [7:0] ea(input int b);
        return 8'((3 + b) * 16 + 4);
    endfunction

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        for (int b = 0; b < NB; b++) begin
            if (a == fa(b)) return {4'h0, m_flag[b*4 +: 4]};
            if (a == ea(b)) return {4'h0, m_en[b*4 +: 4]};
        end
        return 8'h00;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    // one clock cycle with given event and bus inputs; model tracks design
    task automatic step(input logic [15:0] ev, input logic sel, input logic we,
                        input logic [7:0] a, input logic [7:0] d);
        logic [15:0] rise, clr;
        logic [3:0]  nl;
        @(negedge clk);
        evt_i = ev; bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        for (int b = 0; b < NB; b++) nl[b] = |(m_flag[b*4 +: 4] & m_en[b*4 +: 4]);
        rise = ev & ~m_prev;
        clr = '0;
        for (int b = 0; b < NB; b++) begin
            if (sel && we && a == fa(b)) clr[b*4 +: 4] = d[3:0];
            if (sel && we && a == ea(b)) begin
                if (d[7]) m_en[b*4 +: 4] = m_en[b*4 +: 4] | d[3:0];
                else      m_en[b*4 +: 4] = m_en[b*4 +: 4] & ~d[3:0];
            end
        end
        m_flag = (m_flag & ~clr) | rise;
        m_prev = ev;
        m_lvl = nl;
        #1;
        chk("R7 level", {4'h0, irq_lvl_o}, {4'h0, m_lvl});
    endtask

    task automatic rd(input string tag, input logic [7:0] a);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp_rd(a));
    endtask

    task automatic sweep(input string tag);
        for (int b = 0; b < NB; b++) begin
            rd(tag, fa(b));
            rd(tag, ea(b));
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] ev;
        logic [7:0]  a, d;
        ev = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset state
        #1 chk("R1 levels", {4'h0, irq_lvl_o}, 8'h00);
        sweep("R1 reset read");
        // R5: enable set with bit7
        step(16'h0000, 1, 1, ea(0), 8'h81);
        rd("R5 enable set", ea(0));
        // R2: pulse sets flag, R7 level follows
        step(16'h0001, 0, 0, 8'h00, 8'h00);
        step(16'h0000, 0, 0, 8'h00, 8'h00);
        rd("R2 flag set", fa(0));
        chk("R7 bank0 level3", {4'h0, irq_lvl_o}, 8'h01);
        // R3: write 0 no change, write 1 clears
        step(16'h0000, 1, 1, fa(0), 8'hF0);
        rd("R3 zero write keeps", fa(0));
        step(16'h0000, 1, 1, fa(0), 8'h01);
        rd("R3 clear", fa(0));
        step(16'h0000, 0, 0, 8'h00, 8'h00);
        chk("R7 deassert", {4'h0, irq_lvl_o}, 8'h00);
        // R2: held high sets only once
        step(16'h0002, 0, 0, 8'h00, 8'h00);
        step(16'h0002, 1, 1, fa(0), 8'h02);
        step(16'h0002, 0, 0, 8'h00, 8'h00);
        rd("R2 held high once", fa(0));
        // R4: rise and clear same cycle
        step(16'h0000, 0, 0, 8'h00, 8'h00);
        step(16'h0004, 1, 1, fa(0), 8'h0F);
        rd("R4 set wins", fa(0));
        // R6: clear with bit7 low, others unchanged
        step(16'h0000, 1, 1, ea(1), 8'h8F);
        step(16'h0000, 1, 1, ea(1), 8'h05);
        rd("R6 enable clear", ea(1));
        // R7: bank mapping, source 11 -> level 5 line
        step(16'h0000, 1, 1, ea(2), 8'h88);
        step(16'h0800, 0, 0, 8'h00, 8'h00);
        step(16'h0000, 0, 0, 8'h00, 8'h00);
        chk("R7 bank2 level5", {4'h0, irq_lvl_o}, 8'h04);
        // R9: unmapped writes ignored, reads zero
        step(16'h0000, 1, 1, 8'h38, 8'hFF);
        step(16'h0000, 1, 1, 8'h70, 8'h8F);
        step(16'h0000, 1, 1, 8'h24, 8'h8F);
        step(16'h0000, 1, 1, 8'h35, 8'h8F);
        sweep("R9 unchanged");
        rd("R9 unmapped read", 8'h38);
        rd("R9 unmapped read", 8'h70);
        rd("R9 unmapped read", 8'h00);
        // random phase
        for (int k = 0; k < 4000; k++) begin
            ev = ev ^ (16'($urandom) & 16'($urandom) & 16'($urandom));
            case ($urandom % 6)
                0: a = fa($urandom % 4);
                1: a = ea($urandom % 4);
                2: a = 8'($urandom);
                default: a = 8'h00;
            endcase
            d = 8'($urandom);
            step(ev, ($urandom % 2) == 0, ($urandom % 3) != 0, a, d);
            if (k % 200 == 199) sweep("R8 random read");
        end
        // R10: init sequence disables and clears all
        ev = '0;
        for (int b = 0; b < NB; b++) step(ev, 1, 1, ea(b), 8'h0F);
        for (int b = 0; b < NB; b++) step(ev, 1, 1, fa(b), 8'h0F);
        step(ev, 0, 0, 8'h00, 8'h00);
        sweep("R10 init");
        chk("R10 levels", {4'h0, irq_lvl_o}, 8'h00);
        finish_run();
    end
endmodule